// File: doc/BRIEF.md
# Page Home-Node Allocator

This block decides which node of a distributed shared memory owns a given page of the global address space. A request carries a page number (the byte address divided by 4096, so the page is the address with its low twelve bits dropped) and the identity of the requesting node. After a few cycles the block returns the home node of that page and a flag telling whether the home is a different node from the requester.

The placement rule is picked per request by a mode input. There are five stateless rules: cyclic interleave, a single fixed node, contiguous blocks, a skewed interleave, and a two-stage interleave over a prime number of virtual nodes. The sixth rule is stateful: the first node to touch a page becomes its owner for good, and the block remembers that owner in a small table. Divisions and remainders by non-power-of-two constants are done by a shared bit-serial divider. This keeps the logic shallow at the cost of a multi-cycle answer. Requests are handled one at a time, with a ready/valid pair at the edge.

Top module: `page_home_alloc`

## Requirements
- R1: Mode encoding on `mode`: 0 cyclic, 1 single node, 2 block, 3 skew, 4 prime, 5 first-touch. The values 6 and 7 behave exactly like mode 0.
- R2: In cyclic mode, page i is homed on node i mod NODES.
- R3: In single-node mode, every page is homed on the value of `fullNode` sampled with the request.
- R4: In block mode, page i is homed on node floor(i / B), where B = ceil(2^PAGE_W / NODES). For the defaults (6 nodes, 1024 pages) B = 171.
- R5: In skew mode, page i is homed on node (i + floor(i/NODES) + 1) mod NODES.
- R6: In prime mode, P is the smallest prime not below NODES (7 for 6 nodes) and v = i mod P. If v < NODES the home is v. Otherwise the home is (floor(i/P)*(P-NODES) + v - NODES) mod NODES, which is the running index of such overflow pages, dealt cyclically.
- R7: In first-touch mode, for a page below FT_PAGES (64 by default), the first requester becomes the home and every later request returns that node, whoever asks.
- R8: A one-cycle pulse on `ftClear` forgets every first-touch owner, so the next requester of any page becomes its new owner.
- R9: In first-touch mode, a page at or above FT_PAGES is homed as in cyclic mode, and no owner is recorded for it.
- R10: `isRemote` is 1 exactly when `homeNode` differs from the requesting node. Both outputs are valid in the cycle `outValid` is high.
- R11: `reqReady` is high only when no request is in flight. While it is low, `reqValid` and the request inputs are ignored. Each accepted request yields exactly one single-cycle `outValid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted this cycle if valid |
| reqPage | input | PAGE_W | Page number (byte address / 4096) |
| reqNode | input | NODE_W | Requesting node |
| mode | input | 3 | Placement rule select |
| fullNode | input | NODE_W | Home node for single-node mode |
| ftClear | input | 1 | Forget all first-touch owners |
| outValid | output | 1 | Result pulse |
| homeNode | output | NODE_W | Home node of the requested page |
| isRemote | output | 1 | Home differs from requester |

## Verification
The bound checker watches the handshake on every cycle. It checks that ready is low while a result is out, that every result is a single pulse, and that an accepted request drops ready. On every result it also checks that the home node lies inside the node range, that the remote flag matches the requester it captured, and that single-node mode returns the captured node. The arithmetic of the cyclic, block, skew and prime rules can only be shown by the bench scenarios at chosen boundary pages. The same holds for the history that first-touch ownership and its clear depend on.

// File: rtl/page_home_pkg.sv
package page_home_pkg;

  typedef enum logic [2:0] {
    MODE_RR    = 3'd0,
    MODE_FULL  = 3'd1,
    MODE_BLOCK = 3'd2,
    MODE_SKEW  = 3'd3,
    MODE_PRIME = 3'd4,
    MODE_FIRST = 3'd5
  } allocMode_e;

  typedef enum logic [1:0] {NUM_PAGE, NUM_SKEW, NUM_PRIME} numSel_e;
  typedef enum logic [1:0] {DEN_NODES, DEN_BLOCK, DEN_PRIME} denSel_e;
  typedef enum logic [2:0] {RES_REM, RES_QUO, RES_FULL, RES_TABLE, RES_REQ} resSel_e;

  typedef struct packed {
    logic    capture;
    logic    divStart;
    numSel_e numSel;
    denSel_e denSel;
    logic    resLoad;
    resSel_e resSel;
    logic    ftWrite;
    logic    outFire;
  } ctrlStrobe_t;

  typedef struct packed {
    allocMode_e mode;
    logic       divDone;
    logic       primeLow;
    logic       ftInRange;
    logic       ftHit;
  } ctrlStatus_t;

  function automatic bit isPrime(int v);
    if (v < 2) return 1'b0;
    for (int d = 2; d * d <= v; d++) begin
      if (v % d == 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int nextPrime(int n);
    int cand;
    cand = (n < 2) ? 2 : n;
    for (int k = 0; k < 256; k++) begin
      if (isPrime(cand)) return cand;
      cand++;
    end
    return cand;
  endfunction

endpackage

// File: rtl/page_home_ctrl.sv
module page_home_ctrl
  import page_home_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  ctrlStatus_t status,
  output ctrlStrobe_t strobe,
  output logic        reqReady
);

  typedef enum logic [2:0] {ST_IDLE, ST_DECIDE, ST_DIV1, ST_DIV2, ST_EMIT} ctrlState_e;

  ctrlState_e stateQ, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= nextState;
  end

  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    strobe    = '0;
    nextState = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState      = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        strobe.divStart = 1'b1;
        strobe.numSel   = NUM_PAGE;
        strobe.denSel   = DEN_NODES;
        nextState       = ST_DIV1;
        case (status.mode)
          MODE_FULL: begin
            strobe.divStart = 1'b0;
            strobe.resLoad  = 1'b1;
            strobe.resSel   = RES_FULL;
            nextState       = ST_EMIT;
          end
          MODE_BLOCK: strobe.denSel = DEN_BLOCK;
          MODE_PRIME: strobe.denSel = DEN_PRIME;
          MODE_FIRST: begin
            if (status.ftInRange) begin
              strobe.divStart = 1'b0;
              strobe.resLoad  = 1'b1;
              nextState       = ST_EMIT;
              if (status.ftHit) begin
                strobe.resSel = RES_TABLE;
              end else begin
                strobe.resSel  = RES_REQ;
                strobe.ftWrite = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
      ST_DIV1: begin
        if (status.divDone) begin
          strobe.resLoad = 1'b1;
          strobe.resSel  = RES_REM;
          nextState      = ST_EMIT;
          case (status.mode)
            MODE_BLOCK: strobe.resSel = RES_QUO;
            MODE_SKEW: begin
              strobe.resLoad  = 1'b0;
              strobe.divStart = 1'b1;
              strobe.numSel   = NUM_SKEW;
              strobe.denSel   = DEN_NODES;
              nextState       = ST_DIV2;
            end
            MODE_PRIME: begin
              if (!status.primeLow) begin
                strobe.resLoad  = 1'b0;
                strobe.divStart = 1'b1;
                strobe.numSel   = NUM_PRIME;
                strobe.denSel   = DEN_NODES;
                nextState       = ST_DIV2;
              end
            end
            default: ;
          endcase
        end
      end
      ST_DIV2: begin
        if (status.divDone) begin
          strobe.resLoad = 1'b1;
          strobe.resSel  = RES_REM;
          nextState      = ST_EMIT;
        end
      end
      ST_EMIT: begin
        strobe.outFire = 1'b1;
        nextState      = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/page_home_dp.sv
module page_home_dp
  import page_home_pkg::*;
#(
  parameter int NODES    = 6,
  parameter int PRIME    = 7,
  parameter int PAGE_W   = 10,
  parameter int FT_PAGES = 64,
  localparam int NODE_W  = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [2:0]        mode,
  input  logic [NODE_W-1:0] fullNode,
  input  logic              ftClear,
  input  ctrlStrobe_t       strobe,
  output ctrlStatus_t       status,
  output logic [NODE_W-1:0] homeNode,
  output logic              isRemote
);

  localparam int DW       = PAGE_W + 1;
  localparam int CNT_W    = $clog2(DW + 1);
  localparam int PAGES    = 1 << PAGE_W;
  localparam int BLK      = (PAGES + NODES - 1) / NODES;
  localparam int FT_W     = $clog2(FT_PAGES);
  localparam logic [PAGE_W:0] FT_LIMIT = (PAGE_W + 1)'(FT_PAGES);

  // captured request
  logic [PAGE_W-1:0] pageQ;
  logic [NODE_W-1:0] nodeQ;
  logic [NODE_W-1:0] fullQ;
  allocMode_e        modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      nodeQ <= '0;
      fullQ <= '0;
      modeQ <= MODE_RR;
    end else if (strobe.capture) begin
      pageQ <= reqPage;
      nodeQ <= reqNode;
      fullQ <= fullNode;
      modeQ <= (mode > 3'd5) ? MODE_RR : allocMode_e'(mode);
    end
  end

  // bit-serial restoring divider
  logic [DW-1:0]    accQ, quoQ, denQ;
  logic [CNT_W-1:0] cntQ;
  logic             runQ, doneQ;
  logic [DW-1:0]    numMux, denMux;
  logic [DW:0]      trial;
  logic             fits;

  always_comb begin
    case (strobe.numSel)
      NUM_SKEW:  numMux = DW'(pageQ) + quoQ + DW'(1);
      NUM_PRIME: numMux = quoQ * DW'(PRIME - NODES) + accQ - DW'(NODES);
      default:   numMux = DW'(pageQ);
    endcase
    case (strobe.denSel)
      DEN_BLOCK: denMux = DW'(BLK);
      DEN_PRIME: denMux = DW'(PRIME);
      default:   denMux = DW'(NODES);
    endcase
  end

  assign trial = {accQ, quoQ[DW-1]};
  assign fits  = (trial >= {1'b0, denQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      quoQ  <= '0;
      denQ  <= '0;
      cntQ  <= '0;
      runQ  <= 1'b0;
      doneQ <= 1'b0;
    end else if (strobe.divStart) begin
      accQ  <= '0;
      quoQ  <= numMux;
      denQ  <= denMux;
      cntQ  <= CNT_W'(DW);
      runQ  <= 1'b1;
      doneQ <= 1'b0;
    end else if (runQ) begin
      accQ <= fits ? (trial[DW-1:0] - denQ) : trial[DW-1:0];
      quoQ <= {quoQ[DW-2:0], fits};
      cntQ <= cntQ - CNT_W'(1);
      if (cntQ == CNT_W'(1)) begin
        runQ  <= 1'b0;
        doneQ <= 1'b1;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  // first-touch ownership table
  logic [FT_W-1:0]   ftIdx;
  logic              ftValidQ [FT_PAGES];
  logic [NODE_W-1:0] ftNodeQ  [FT_PAGES];

  assign ftIdx = pageQ[FT_W-1:0];

  for (genvar e = 0; e < FT_PAGES; e++) begin : g_ftEntry
    logic hitWrite;
    assign hitWrite = strobe.ftWrite && (ftIdx == FT_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         ftValidQ[e] <= 1'b0;
      else if (ftClear)  ftValidQ[e] <= 1'b0;
      else if (hitWrite) ftValidQ[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hitWrite) ftNodeQ[e] <= nodeQ;
    end
  end

  assign status.mode      = modeQ;
  assign status.divDone   = doneQ;
  assign status.primeLow  = (accQ < DW'(NODES));
  assign status.ftInRange = ({1'b0, pageQ} < FT_LIMIT);
  assign status.ftHit     = ftValidQ[ftIdx];

  // result register
  logic [NODE_W-1:0] resMux;
  logic [NODE_W-1:0] homeQ;
  logic              remoteQ;

  always_comb begin
    case (strobe.resSel)
      RES_QUO:   resMux = quoQ[NODE_W-1:0];
      RES_FULL:  resMux = fullQ;
      RES_TABLE: resMux = ftNodeQ[ftIdx];
      RES_REQ:   resMux = nodeQ;
      default:   resMux = accQ[NODE_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      homeQ   <= '0;
      remoteQ <= 1'b0;
    end else if (strobe.resLoad) begin
      homeQ   <= resMux;
      remoteQ <= (resMux != nodeQ);
    end
  end

  assign homeNode = homeQ;
  assign isRemote = remoteQ;

endmodule

// File: rtl/page_home_alloc.sv
module page_home_alloc
  import page_home_pkg::*;
#(
  parameter int NODES    = 6,
  parameter int PAGE_W   = 10,
  parameter int FT_PAGES = 64,
  localparam int NODE_W  = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [2:0]        mode,
  input  logic [NODE_W-1:0] fullNode,
  input  logic              ftClear,
  output logic              outValid,
  output logic [NODE_W-1:0] homeNode,
  output logic              isRemote
);

  localparam int PRIME = nextPrime(NODES);

  ctrlStrobe_t strobe;
  ctrlStatus_t status;

  page_home_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .status   (status),
    .strobe   (strobe),
    .reqReady (reqReady)
  );

  page_home_dp #(
    .NODES    (NODES),
    .PRIME    (PRIME),
    .PAGE_W   (PAGE_W),
    .FT_PAGES (FT_PAGES)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqPage  (reqPage),
    .reqNode  (reqNode),
    .mode     (mode),
    .fullNode (fullNode),
    .ftClear  (ftClear),
    .strobe   (strobe),
    .status   (status),
    .homeNode (homeNode),
    .isRemote (isRemote)
  );

  assign outValid = strobe.outFire;

endmodule

// File: rtl/page_home_checker.sv
module page_home_checker #(
  parameter int NODES   = 6,
  localparam int NODE_W = $clog2(NODES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [NODE_W-1:0] reqNode,
  input logic [2:0]        mode,
  input logic [NODE_W-1:0] fullNode,
  input logic              outValid,
  input logic [NODE_W-1:0] homeNode,
  input logic              isRemote
);

  logic [NODE_W-1:0] lastNodeQ, lastFullQ;
  logic [2:0]        lastModeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastNodeQ <= '0;
      lastFullQ <= '0;
      lastModeQ <= '0;
    end else if (reqValid && reqReady) begin
      lastNodeQ <= reqNode;
      lastFullQ <= fullNode;
      lastModeQ <= mode;
    end
  end

  AST_BUSY_WHEN_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !reqReady); // R11
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R11
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R11
  AST_HOME_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({1'b0, homeNode} < (NODE_W + 1)'(NODES))); // R2
  AST_REMOTE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (isRemote == (homeNode != lastNodeQ))); // R10
  AST_FULL_NODE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && lastModeQ == 3'd1) |-> (homeNode == lastFullQ)); // R3

endmodule

bind page_home_alloc page_home_checker #(.NODES(NODES)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqNode  (reqNode),
  .mode     (mode),
  .fullNode (fullNode),
  .outValid (outValid),
  .homeNode (homeNode),
  .isRemote (isRemote)
);

// File: tb/test_page_home_alloc.sv
module test_page_home_alloc;

  localparam int N      = 6;
  localparam int P      = 7;     // smallest prime >= 6
  localparam int PW     = 10;
  localparam int NPAGES = 1024;
  localparam int BSIZE  = (NPAGES + N - 1) / N;
  localparam int FTN    = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [PW-1:0] reqPage = '0;
  logic [2:0] reqNode = '0;
  logic [2:0] mode = '0;
  logic [2:0] fullNode = '0;
  logic       ftClear = 1'b0;
  logic       outValid;
  logic [2:0] homeNode;
  logic       isRemote;

  page_home_alloc i_page_home_alloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPage(reqPage), .reqNode(reqNode), .mode(mode), .fullNode(fullNode),
    .ftClear(ftClear), .outValid(outValid), .homeNode(homeNode), .isRemote(isRemote)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit monOn = 1'b0;
  bit pending = 1'b0;
  int expHome;
  int expRem;
  string expTag;
  int ftV [FTN];
  int ftN [FTN];

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic int refHome(int m, int pg, int nd, int fl);
    int v;
    if (m > 5) m = 0;
    case (m)
      1: return fl;
      2: return pg / BSIZE;
      3: return (pg + pg / N + 1) % N;
      4: begin
        v = pg % P;
        if (v < N) return v;
        return ((pg / P) * (P - N) + v - N) % N;
      end
      5: begin
        if (pg >= FTN) return pg % N;
        if (ftV[pg] != 0) return ftN[pg];
        ftV[pg] = 1;
        ftN[pg] = nd;
        return nd;
      end
      default: return pg % N;
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (monOn) begin
      cyc++;
      total++;
      if (reqReady !== !pending) begin
        bad++;
        $display("FAIL R11 reqReady got %0b exp %0b", reqReady, !pending);
      end
      if (outValid) begin
        if (!pending) begin
          total++; bad++;
          $display("FAIL R11 outValid got 1 exp 0");
        end else begin
          total += 2;
          if (homeNode !== 3'(expHome)) begin
            bad++;
            $display("FAIL %s homeNode got %0d exp %0d", expTag, homeNode, expHome);
          end
          if (isRemote !== 1'(expRem)) begin
            bad++;
            $display("FAIL R10 (%s) isRemote got %0b exp %0b", expTag, isRemote, expRem);
          end
          pending = 1'b0;
        end
      end
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog cycles got %0d exp below 100000", cyc);
        finishRun();
      end
    end
  end

  task automatic doReq(int m, int pg, int nd, int fl, string tag, bit junk);
    while (!reqReady) begin
      @(posedge clk); #1;
    end
    reqValid = 1'b1;
    mode     = 3'(m);
    reqPage  = PW'(pg);
    reqNode  = 3'(nd);
    fullNode = 3'(fl);
    expHome  = refHome(m, pg, nd, fl);
    expRem   = (expHome != nd) ? 1 : 0;
    expTag   = tag;
    @(posedge clk); #1;
    pending = 1'b1;
    if (junk) begin
      // R11: inputs and valid while busy must be ignored
      reqPage  = PW'(pg ^ 10'h2A5);
      reqNode  = 3'((nd + 3) % N);
      mode     = 3'd1;
      fullNode = 3'd5;
      @(posedge clk); #1;
      @(posedge clk); #1;
    end
    reqValid = 1'b0;
    while (pending) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulseClear();
    @(posedge clk); #1;
    ftClear = 1'b1;
    for (int k = 0; k < FTN; k++) ftV[k] = 0;
    @(posedge clk); #1;
    ftClear = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < FTN; k++) begin ftV[k] = 0; ftN[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    total += 2;
    if (reqReady !== 1'b1) begin
      bad++; $display("FAIL R11 reset reqReady got %0b exp 1", reqReady);
    end
    if (outValid !== 1'b0) begin
      bad++; $display("FAIL R11 reset outValid got %0b exp 0", outValid);
    end
    monOn = 1'b1;
    @(posedge clk); #1;

    // R2 cyclic
    doReq(0, 0, 1, 0, "R2 page0", 1'b0);
    doReq(0, 5, 1, 0, "R2 page5", 1'b1);
    doReq(0, 6, 0, 0, "R2 page6", 1'b0);
    doReq(0, 13, 1, 0, "R2 page13", 1'b0);
    doReq(0, 1023, 3, 0, "R2 page1023", 1'b1);
    // R3 single node
    doReq(1, 3, 4, 4, "R3 page3", 1'b0);
    doReq(1, 900, 0, 2, "R3 page900", 1'b0);
    // R4 block
    doReq(2, 0, 0, 0, "R4 page0", 1'b0);
    doReq(2, 170, 2, 0, "R4 page170", 1'b1);
    doReq(2, 171, 1, 0, "R4 page171", 1'b0);
    doReq(2, 341, 1, 0, "R4 page341", 1'b0);
    doReq(2, 342, 3, 0, "R4 page342", 1'b0);
    doReq(2, 1023, 5, 0, "R4 page1023", 1'b0);
    // R5 skew
    doReq(3, 0, 1, 0, "R5 page0", 1'b0);
    doReq(3, 5, 0, 0, "R5 page5", 1'b1);
    doReq(3, 6, 2, 0, "R5 page6", 1'b0);
    doReq(3, 13, 4, 0, "R5 page13", 1'b0);
    doReq(3, 1023, 0, 0, "R5 page1023", 1'b0);
    // R6 prime
    doReq(4, 5, 5, 0, "R6 page5", 1'b0);
    doReq(4, 6, 1, 0, "R6 page6", 1'b1);
    doReq(4, 8, 1, 0, "R6 page8", 1'b0);
    doReq(4, 13, 1, 0, "R6 page13", 1'b0);
    doReq(4, 20, 0, 0, "R6 page20", 1'b0);
    doReq(4, 27, 3, 0, "R6 page27", 1'b0);
    doReq(4, 1023, 2, 0, "R6 page1023", 1'b0);
    // R7 first touch
    doReq(5, 10, 2, 0, "R7 first page10", 1'b0);
    doReq(5, 10, 5, 0, "R7 later page10", 1'b0);
    doReq(5, 63, 0, 0, "R7 first page63", 1'b0);
    doReq(5, 63, 4, 0, "R7 later page63", 1'b0);
    // R9 outside the table
    doReq(5, 64, 3, 0, "R9 page64", 1'b0);
    doReq(5, 64, 1, 0, "R9 page64 again", 1'b1);
    doReq(5, 0, 3, 0, "R7 first page0", 1'b0);
    // R8 clear
    pulseClear();
    doReq(5, 10, 5, 0, "R8 page10 after clear", 1'b0);
    doReq(5, 10, 1, 0, "R8 page10 new owner", 1'b0);
    doReq(5, 0, 4, 0, "R8 page0 after clear", 1'b0);
    // R1 spare codes behave as cyclic
    doReq(6, 13, 1, 0, "R1 mode6", 1'b0);
    doReq(7, 1022, 2, 0, "R1 mode7", 1'b1);

    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule